// File: doc/BRIEF.md
# Banked Data Memory Front End with Pointer Access

This block sits between a small 8-bit core and its data storage. The core presents a 7-bit file address on every access. For a direct access, a bank-select register supplies the upper address bits, so the data space appears as 32 banks of 128 bytes. Every bank has the same layout. The low offsets reach a small set of core registers that are the same in every bank. Next come peripheral-register slots, which this block leaves empty. After those comes per-bank general RAM. The top offsets reach a shared RAM that is the same 16 bytes whichever bank is selected.

Two 16-bit pointers give indirect access. Each pointer has its own data port, and that port reads or writes whatever location the pointer names. When the top bit of a pointer is set, its data port reads program memory instead of RAM and returns the low byte of the addressed word. That read takes one extra cycle. A two-state sequencer (`ST_READY`, `ST_PM_WAIT`) manages this cycle by raising a stall output. The core holds its request while the stall is high and during the cycle that follows it.

Top module: `banked_data_mem`

## Requirements
- R1: A synchronous reset clears the bank-select register (offset 0x08) and both pointers (pointer 0 low/high at 0x04/0x05, pointer 1 low/high at 0x06/0x07), and these then read back as zero.
- R2: A direct access to offsets 0x20–0x6F reaches general RAM in the bank named by the bank-select register, and equal offsets in different banks hold independent bytes.
- R3: Offsets 0x00–0x0B reach the same core registers whatever bank is selected.
- R4: Offsets 0x70–0x7F reach one set of 16 shared bytes from every bank.
- R5: Reads of the peripheral region 0x0C–0x1F, and of core offsets that hold no register (0x02, 0x03, 0x09–0x0B), return zero, and writes to them have no effect. Bank-select bits above the bank width read as zero.
- R6: In data mode (pointer bit 15 clear), the data port at offset 0x00 (pointer 0) or 0x01 (pointer 1) reads and writes the location with bank = pointer bits 11:7 and offset = pointer bits 6:0. The bank-select register and pointer bits 14:12 do not affect this.
- R7: An indirect access whose target offset is a core register reads or writes that register.
- R8: With pointer bit 15 set, a read of that pointer's data port requests program-memory word address = pointer bits 14:0 and returns the low 8 bits of that word.
- R9: A program-memory read keeps the stall output high for exactly one cycle in `ST_READY`, and the data appears in the following cycle in `ST_PM_WAIT`. No other access raises the stall.
- R10: A write through a data port whose pointer has bit 15 set changes no storage and issues no program-memory request.
- R11: An indirect access whose target is either data port (offset 0x00 or 0x01, data mode) reads zero, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 7 | File address from the core |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (combinational, valid while stall is low) |
| cpu_stall | output | 1 | Hold request one more cycle |
| pm_rd | output | 1 | Program-memory read strobe |
| pm_addr | output | 15 | Program-memory word address |
| pm_data | input | 14 | Program-memory word, one cycle after the strobe |

## Verification
The bench builds the block with its default parameters: five bank bits, 80 general bytes per bank and 16 shared bytes. With these values bank 31 and the full 15-bit program address range can be reached. The bench writes equal offsets in banks 3 and 31 and reads shared bytes from bank 17 after writing them from bank 2. It points pointers at core registers, at the data ports themselves and at program words 0x0123 and 0x7FFF. It also checks that the extra program-memory cycle appears only on those reads.

// File: rtl/bdm_pkg.sv
`timescale 1ns/1ps
package bdm_pkg;

    localparam int NPTR      = 2;
    localparam int PTR_W     = 16;
    localparam int OFF_W     = 7;
    localparam int PM_FLAG   = 15;
    localparam int BANK_LSB  = 7;

    localparam logic [OFF_W-1:0] OFF_IND0  = 7'h00;
    localparam logic [OFF_W-1:0] OFF_IND1  = 7'h01;
    localparam int               OFF_PBASE = 4;
    localparam logic [OFF_W-1:0] OFF_BSEL  = 7'h08;
    localparam logic [OFF_W-1:0] CORE_HI   = 7'h0B;
    localparam logic [OFF_W-1:0] GPR_LO    = 7'h20;

    typedef enum logic [2:0] {
        RG_CORE,
        RG_SFR,
        RG_GPR,
        RG_SHR,
        RG_NONE
    } region_t;

    typedef enum logic {
        ST_READY,
        ST_PM_WAIT
    } seq_state_t;

endpackage

// File: rtl/bdm_route.sv
`timescale 1ns/1ps
module bdm_route
    import bdm_pkg::*;
#(
    parameter int BANK_W    = 5,
    parameter int GPR_BYTES = 80,
    parameter int SHR_BYTES = 16,
    parameter int PM_AW     = 15
) (
    input  logic [OFF_W-1:0]            cpu_addr,
    input  logic [BANK_W-1:0]           bsr,
    input  logic [NPTR-1:0][PTR_W-1:0]  ptr,
    output logic                        tgt_pm,
    output logic                        tgt_self,
    output logic [BANK_W-1:0]           tgt_bank,
    output logic [OFF_W-1:0]            tgt_off,
    output region_t                     tgt_region,
    output logic [PM_AW-1:0]            tgt_pm_addr
);

    localparam logic [OFF_W-1:0] GPR_HI = 7'(int'(GPR_LO) + GPR_BYTES - 1);
    localparam logic [OFF_W-1:0] SHR_LO = 7'(128 - SHR_BYTES);

    logic             via_ptr;
    logic [PTR_W-1:0] sel_ptr;

    always_comb begin
        via_ptr     = (cpu_addr == OFF_IND0) || (cpu_addr == OFF_IND1);
        sel_ptr     = ptr[cpu_addr[0]];
        tgt_pm_addr = sel_ptr[PM_AW-1:0];
        if (via_ptr) begin
            tgt_pm   = sel_ptr[PM_FLAG];
            tgt_bank = sel_ptr[BANK_LSB +: BANK_W];
            tgt_off  = sel_ptr[OFF_W-1:0];
            tgt_self = !sel_ptr[PM_FLAG] &&
                       ((sel_ptr[OFF_W-1:0] == OFF_IND0) || (sel_ptr[OFF_W-1:0] == OFF_IND1));
        end else begin
            tgt_pm   = 1'b0;
            tgt_bank = bsr;
            tgt_off  = cpu_addr;
            tgt_self = 1'b0;
        end
    end

    always_comb begin
        if (tgt_off <= CORE_HI)
            tgt_region = RG_CORE;
        else if (tgt_off < GPR_LO)
            tgt_region = RG_SFR;
        else if (tgt_off <= GPR_HI)
            tgt_region = RG_GPR;
        else if (tgt_off >= SHR_LO)
            tgt_region = RG_SHR;
        else
            tgt_region = RG_NONE;
    end

    logic unused_bits;
    assign unused_bits = ^sel_ptr;

endmodule

// File: rtl/bdm_core_regs.sv
`timescale 1ns/1ps
module bdm_core_regs
    import bdm_pkg::*;
#(
    parameter int BANK_W = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [OFF_W-1:0]            off,
    input  logic [7:0]                  wdata,
    output logic [7:0]                  rdata,
    output logic [BANK_W-1:0]           bsr_q,
    output logic [NPTR-1:0][PTR_W-1:0]  ptr_q
);

    always_ff @(posedge clk) begin
        if (rst)
            bsr_q <= '0;
        else if (we && off == OFF_BSEL)
            bsr_q <= wdata[BANK_W-1:0];
    end

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        localparam logic [OFF_W-1:0] LO_OFF = 7'(OFF_PBASE + 2 * g);
        localparam logic [OFF_W-1:0] HI_OFF = 7'(OFF_PBASE + 2 * g + 1);
        always_ff @(posedge clk) begin
            if (rst)
                ptr_q[g] <= '0;
            else if (we && off == LO_OFF)
                ptr_q[g][7:0] <= wdata;
            else if (we && off == HI_OFF)
                ptr_q[g][15:8] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (off == OFF_BSEL)
            rdata = 8'(bsr_q);
        for (int g = 0; g < NPTR; g++) begin
            if (off == 7'(OFF_PBASE + 2 * g))
                rdata = ptr_q[g][7:0];
            if (off == 7'(OFF_PBASE + 2 * g + 1))
                rdata = ptr_q[g][15:8];
        end
    end

endmodule

// File: rtl/bdm_ram.sv
`timescale 1ns/1ps
module bdm_ram
    import bdm_pkg::*;
#(
    parameter int BANK_W    = 5,
    parameter int GPR_BYTES = 80,
    parameter int SHR_BYTES = 16
) (
    input  logic              clk,
    input  logic              gpr_we,
    input  logic              shr_we,
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  off,
    input  logic [7:0]        wdata,
    output logic [7:0]        gpr_rdata,
    output logic [7:0]        shr_rdata
);

    localparam int NBANK     = 1 << BANK_W;
    localparam int GPR_TOTAL = NBANK * GPR_BYTES;
    localparam int GIDX_W    = $clog2(GPR_TOTAL);
    localparam int SIDX_W    = $clog2(SHR_BYTES);
    localparam logic [OFF_W-1:0] SHR_LO = 7'(128 - SHR_BYTES);

    logic [7:0] gpr_mem [GPR_TOTAL];
    logic [7:0] shr_mem [SHR_BYTES];

    logic [GIDX_W-1:0] gidx;
    logic [SIDX_W-1:0] sidx;
    logic [OFF_W-1:0]  grel;
    logic [OFF_W-1:0]  srel;

    always_comb begin
        grel = off - GPR_LO;
        srel = off - SHR_LO;
        gidx = GIDX_W'(bank) * GIDX_W'(GPR_BYTES) + GIDX_W'(grel);
        sidx = srel[SIDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (gpr_we)
            gpr_mem[gidx] <= wdata;
        if (shr_we)
            shr_mem[sidx] <= wdata;
    end

    assign gpr_rdata = (int'(gidx) < GPR_TOTAL) ? gpr_mem[gidx] : 8'h00;
    assign shr_rdata = shr_mem[sidx];

    logic unused_srel;
    assign unused_srel = ^srel;

endmodule

// File: rtl/bdm_seq.sv
`timescale 1ns/1ps
module bdm_seq
    import bdm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_req,
    input  logic pm_target,
    output logic stall,
    output logic pm_fetch,
    output logic wr_allow,
    output logic show_pm
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_READY;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        stall    = 1'b0;
        pm_fetch = 1'b0;
        wr_allow = 1'b0;
        show_pm  = 1'b0;
        unique case (state_q)
            ST_READY: begin
                wr_allow = 1'b1;
                if (rd_req && pm_target) begin
                    stall    = 1'b1;
                    pm_fetch = 1'b1;
                    state_d  = ST_PM_WAIT;
                end
            end
            ST_PM_WAIT: begin
                show_pm = 1'b1;
                state_d = ST_READY;
            end
        endcase
    end

endmodule

// File: rtl/banked_data_mem.sv
`timescale 1ns/1ps
module banked_data_mem
    import bdm_pkg::*;
#(
    parameter int BANK_W    = 5,
    parameter int GPR_BYTES = 80,
    parameter int SHR_BYTES = 16,
    parameter int PM_AW     = 15,
    parameter int PM_DW     = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [6:0]       cpu_addr,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    output logic             cpu_stall,
    output logic             pm_rd,
    output logic [PM_AW-1:0] pm_addr,
    input  logic [PM_DW-1:0] pm_data
);

    logic [BANK_W-1:0]          bsr_w;
    logic [NPTR-1:0][PTR_W-1:0] ptr_w;

    logic              tgt_pm;
    logic              tgt_self;
    logic [BANK_W-1:0] tgt_bank;
    logic [OFF_W-1:0]  tgt_off;
    region_t           tgt_region;

    logic wr_allow;
    logic show_pm;
    logic wr_go;
    logic core_we;
    logic gpr_we;
    logic shr_we;

    logic [7:0] core_rd;
    logic [7:0] gpr_rd;
    logic [7:0] shr_rd;

    bdm_route #(
        .BANK_W    (BANK_W),
        .GPR_BYTES (GPR_BYTES),
        .SHR_BYTES (SHR_BYTES),
        .PM_AW     (PM_AW)
    ) u_route (
        .cpu_addr    (cpu_addr),
        .bsr         (bsr_w),
        .ptr         (ptr_w),
        .tgt_pm      (tgt_pm),
        .tgt_self    (tgt_self),
        .tgt_bank    (tgt_bank),
        .tgt_off     (tgt_off),
        .tgt_region  (tgt_region),
        .tgt_pm_addr (pm_addr)
    );

    bdm_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (cpu_rd),
        .pm_target (tgt_pm),
        .stall     (cpu_stall),
        .pm_fetch  (pm_rd),
        .wr_allow  (wr_allow),
        .show_pm   (show_pm)
    );

    always_comb begin
        wr_go   = cpu_wr && wr_allow && !tgt_pm && !tgt_self;
        core_we = wr_go && (tgt_region == RG_CORE);
        gpr_we  = wr_go && (tgt_region == RG_GPR);
        shr_we  = wr_go && (tgt_region == RG_SHR);
    end

    bdm_core_regs #(
        .BANK_W (BANK_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (core_we),
        .off   (tgt_off),
        .wdata (cpu_wdata),
        .rdata (core_rd),
        .bsr_q (bsr_w),
        .ptr_q (ptr_w)
    );

    bdm_ram #(
        .BANK_W    (BANK_W),
        .GPR_BYTES (GPR_BYTES),
        .SHR_BYTES (SHR_BYTES)
    ) u_ram (
        .clk       (clk),
        .gpr_we    (gpr_we),
        .shr_we    (shr_we),
        .bank      (tgt_bank),
        .off       (tgt_off),
        .wdata     (cpu_wdata),
        .gpr_rdata (gpr_rd),
        .shr_rdata (shr_rd)
    );

    always_comb begin
        cpu_rdata = 8'h00;
        if (show_pm) begin
            cpu_rdata = pm_data[7:0];
        end else if (!tgt_pm && !tgt_self) begin
            unique case (tgt_region)
                RG_CORE: cpu_rdata = core_rd;
                RG_GPR:  cpu_rdata = gpr_rd;
                RG_SHR:  cpu_rdata = shr_rd;
                RG_SFR:  cpu_rdata = 8'h00;
                RG_NONE: cpu_rdata = 8'h00;
                default: cpu_rdata = 8'h00;
            endcase
        end
    end

    logic unused_pm;
    assign unused_pm = ^pm_data[PM_DW-1:8];

endmodule

// File: rtl/bdm_checker.sv
`timescale 1ns/1ps
module bdm_checker
    import bdm_pkg::*;
#(
    parameter int BANK_W = 5,
    parameter int PM_AW  = 15
) (
    input logic                        clk,
    input logic                        rst,
    input logic [6:0]                  cpu_addr,
    input logic                        cpu_rd,
    input logic                        cpu_wr,
    input logic                        cpu_stall,
    input logic                        pm_rd,
    input logic [PM_AW-1:0]            pm_addr,
    input logic [BANK_W-1:0]           bsr,
    input logic [NPTR-1:0][PTR_W-1:0]  ptr
);

    logic             on_port;
    logic [PTR_W-1:0] cur_ptr;

    assign on_port = (cpu_addr == OFF_IND0) || (cpu_addr == OFF_IND1);
    assign cur_ptr = ptr[cpu_addr[0]];

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (bsr == '0) && (ptr == '0));

    assert_stall_once_R9: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |=> !cpu_stall);

    assert_no_stall_without_pm_R9: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rd || !on_port) |-> !cpu_stall);

    assert_pm_addr_R8: assert property (@(posedge clk) disable iff (rst)
        pm_rd |-> on_port && cur_ptr[PM_FLAG] && (pm_addr == cur_ptr[PM_AW-1:0]) && cpu_stall);

    assert_pm_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_rd && on_port && cur_ptr[PM_FLAG]) |=> $stable(bsr) && $stable(ptr));

    assert_pm_write_no_fetch_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_rd) |-> !pm_rd);

    assert_self_write_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && on_port && !cur_ptr[PM_FLAG] && (cur_ptr[OFF_W-1:0] <= 7'h01))
        |=> $stable(bsr) && $stable(ptr));

endmodule

bind banked_data_mem bdm_checker #(
    .BANK_W (BANK_W),
    .PM_AW  (PM_AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_stall (cpu_stall),
    .pm_rd     (pm_rd),
    .pm_addr   (pm_addr),
    .bsr       (bsr_w),
    .ptr       (ptr_w)
);

// File: tb/banked_data_mem_test.sv
`timescale 1ns/1ps
module banked_data_mem_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_stall;
    logic        pm_rd;
    logic [14:0] pm_addr;
    logic [13:0] pm_data = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    banked_data_mem uut (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_stall (cpu_stall),
        .pm_rd     (pm_rd),
        .pm_addr   (pm_addr),
        .pm_data   (pm_data)
    );

    // program memory model: one-cycle latency, word derived from its address
    always @(posedge clk)
        if (pm_rd) pm_data <= {pm_addr[13:8] ^ 6'h15, pm_addr[7:0] ^ 8'hA5};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data when a read completes
    always begin
        @(posedge clk);
        #9;
        if (!rst && cpu_rd && !cpu_stall) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected read", int'(cpu_rdata), 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(cpu_rdata === e, t, int'(cpu_rdata), int'(e));
            end
        end
    end

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic pm_read(input logic [6:0] a, input logic [14:0] wa, input logic [7:0] e,
                           input string tag);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        #5;
        check(cpu_stall === 1'b1, "R9 stall on program read", int'(cpu_stall), 1);
        check(pm_rd === 1'b1 && pm_addr === wa, "R8 program word address",
              int'(pm_addr), int'(wa));
        @(negedge clk);
        check(cpu_stall === 1'b0, "R9 stall lasts one cycle", int'(cpu_stall), 0);
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic wr_pm(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        #5;
        check(pm_rd === 1'b0 && cpu_stall === 1'b0, "R10 write issues no fetch",
              int'({pm_rd, cpu_stall}), 0);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(7'h08, 8'h00, "R1 bank select after reset");
        rd(7'h04, 8'h00, "R1 pointer0 low after reset");
        rd(7'h05, 8'h00, "R1 pointer0 high after reset");
        rd(7'h06, 8'h00, "R1 pointer1 low after reset");
        rd(7'h07, 8'h00, "R1 pointer1 high after reset");

        // R2: banked general RAM
        wr(7'h08, 8'd3);  wr(7'h20, 8'h11);
        wr(7'h08, 8'd31); wr(7'h20, 8'h22);
        rd(7'h20, 8'h22, "R2 bank 31 byte");
        wr(7'h08, 8'd3);
        rd(7'h20, 8'h11, "R2 bank 3 byte kept");

        // R3: core registers visible in every bank
        wr(7'h08, 8'd31); wr(7'h04, 8'hAB); wr(7'h08, 8'd0);
        rd(7'h04, 8'hAB, "R3 pointer written in bank 31 read in bank 0");
        wr(7'h08, 8'hFF);
        rd(7'h08, 8'h1F, "R5 bank select upper bits zero");

        // R4: shared RAM
        wr(7'h08, 8'd2); wr(7'h75, 8'h5A); wr(7'h08, 8'd17);
        rd(7'h75, 8'h5A, "R4 shared byte across banks");

        // R5: unimplemented locations
        rd(7'h0C, 8'h00, "R5 peripheral slot low");
        rd(7'h1F, 8'h00, "R5 peripheral slot high");
        rd(7'h02, 8'h00, "R5 empty core offset 0x02");
        rd(7'h0B, 8'h00, "R5 empty core offset 0x0B");
        wr(7'h10, 8'h77);
        rd(7'h10, 8'h00, "R5 write to peripheral slot ignored");

        // R6: pointer data access
        wr(7'h05, 8'h01); wr(7'h04, 8'hA0); wr(7'h08, 8'd31);
        rd(7'h00, 8'h11, "R6 pointer0 reads bank 3 offset 0x20");
        wr(7'h00, 8'h99); wr(7'h08, 8'd3);
        rd(7'h20, 8'h99, "R6 pointer0 write landed");
        wr(7'h07, 8'h04); wr(7'h06, 8'hF5);
        rd(7'h01, 8'h5A, "R6 pointer1 reads shared byte");
        wr(7'h07, 8'h74);
        rd(7'h01, 8'h5A, "R6 pointer bits 14:12 ignored");

        // R7: pointer to a core register
        wr(7'h07, 8'h00); wr(7'h06, 8'h08);
        rd(7'h01, 8'h03, "R7 pointer reads bank select");
        wr(7'h01, 8'h07);
        rd(7'h08, 8'h07, "R7 pointer writes bank select");

        // R11: pointer at a data port
        wr(7'h05, 8'h00); wr(7'h04, 8'h01);
        rd(7'h00, 8'h00, "R11 self-target read zero");
        wr(7'h00, 8'h55);
        rd(7'h06, 8'h08, "R11 pointer1 low untouched");
        rd(7'h04, 8'h01, "R11 pointer0 low untouched");
        rd(7'h01, 8'h07, "R11 bank select untouched");

        // R8 / R9: program memory reads
        wr(7'h05, 8'h81); wr(7'h04, 8'h23);
        pm_read(7'h00, 15'h0123, 8'h86, "R8 program low byte at 0x0123");
        wr(7'h07, 8'hFF); wr(7'h06, 8'hFF);
        pm_read(7'h01, 15'h7FFF, 8'h5A, "R8 program low byte at 0x7FFF");

        // R10: writes in program mode ignored
        wr(7'h08, 8'd2); wr(7'h23, 8'h66); wr(7'h08, 8'd5);
        wr_pm(7'h00, 8'h44);
        rd(7'h04, 8'h23, "R10 pointer0 low unchanged");
        rd(7'h05, 8'h81, "R10 pointer0 high unchanged");
        wr(7'h08, 8'd2);
        rd(7'h23, 8'h66, "R10 RAM under pointer bits unchanged");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule